// File: doc/BRIEF.md
# System Control Port Register Block

This block is a byte-wide register file that sits on a simple I/O bus of a workstation-class platform. It answers one port at 0x092 and a window of ports from 0x800 to 0x851. Some of its ports are control registers. Writing them changes level outputs: a soft-reset request, a little-endian mode flag, a disk activity light and a contiguous I/O map select. Two other ports fire single-cycle pulses that toggle the two lock levels of an external NVRAM. The remaining ports return fixed identity and equipment codes.

The bus has an address, write data, read data and separate read and write strobes. Writes take effect at the clock edge where the write strobe is sampled. Read data is registered: it appears on the cycle after the read strobe and holds until the next read. A read of any port that is not mapped returns all ones. A write to an address the block does not know changes nothing, but it sets a sticky miss flag that only reset clears.

Top module: `sysport_regs`

## Requirements
- R1: A write to 0x092 sets `soft_reset` from data bit 0 and `little_endian` from data bit 1. Both outputs are visible the cycle after the write.
- R2: A read of 0x092 returns `little_endian` in bit 1, with every other bit zero.
- R3: The constant ports read back as follows: 0x800 gives 0xEF, 0x802 gives 0xAD, 0x803 gives 0xE0, 0x80C gives 0x3C, 0x810 gives 0x39, 0x818 gives 0x00, and 0x823 gives 0x03.
- R4: Writes to 0x800, 0x802 and 0x803 change no read value and no output. They do not set `wr_miss`.
- R5: A write to 0x808 sets `disk_led` from data bit 0. A read of 0x808 returns 0xFF.
- R6: A write to 0x810 makes `lock1_pulse` high for exactly one cycle, the cycle after the write. A write to 0x812 does the same on `lock2_pulse`. The data written to either port is ignored.
- R7: 0x81C keeps only data bits 3:0 of a write and reads back as {4'b0, stored bits}.
- R8: A write to 0x850 keeps data bit 0, drives it on `contig_map`, and a read of 0x850 returns {7'b0, bit}.
- R9: A read of any unmapped address returns 0xFF. This includes 0x808, 0x812 and 0x814.
- R10: A write to an address outside {0x092, 0x800, 0x802, 0x803, 0x808, 0x810, 0x812, 0x814, 0x81C, 0x850} changes no state or output. It sets `wr_miss`, which stays set until reset. A write to 0x814 is accepted and has no effect.
- R11: A synchronous active-high `rst` clears every stored bit, every output and `bus_rdata`.
- R12: `bus_rdata` updates only on the cycle after a read strobe and holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Port address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| soft_reset | output | 1 | Soft-reset request level |
| little_endian | output | 1 | Little-endian mode flag |
| disk_led | output | 1 | Disk activity light |
| contig_map | output | 1 | Contiguous I/O map select |
| lock1_pulse | output | 1 | One-cycle toggle for NVRAM lock 1 |
| lock2_pulse | output | 1 | One-cycle toggle for NVRAM lock 2 |
| wr_miss | output | 1 | Sticky flag for writes to unknown addresses |

## Verification
The assertions assume three things about the inputs. The address is valid in every cycle that has a strobe. Reset is held for at least one clock edge. A read and a write in the same cycle are treated as independent operations. The bench drives every strobe for exactly one cycle at the falling edge and returns it to zero before the next access, so each access stands alone. Full sweeps over all 4096 addresses cover reads in two different register states and writes to every unknown address. Each mapped write port is then checked directly at its outputs and read back.

// File: rtl/sysport_regs.sv
module sysport_regs #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic              soft_reset,
  output logic              little_endian,
  output logic              disk_led,
  output logic              contig_map,
  output logic              lock1_pulse,
  output logic              lock2_pulse,
  output logic              wr_miss
);

  localparam logic [ADDR_W-1:0] A_P92  = ADDR_W'('h092);
  localparam logic [ADDR_W-1:0] A_CPU  = ADDR_W'('h800);
  localparam logic [ADDR_W-1:0] A_FEAT = ADDR_W'('h802);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h803);
  localparam logic [ADDR_W-1:0] A_DISK = ADDR_W'('h808);
  localparam logic [ADDR_W-1:0] A_EQP  = ADDR_W'('h80C);
  localparam logic [ADDR_W-1:0] A_LK1  = ADDR_W'('h810);
  localparam logic [ADDR_W-1:0] A_LK2  = ADDR_W'('h812);
  localparam logic [ADDR_W-1:0] A_L2   = ADDR_W'('h814);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'('h818);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'('h81C);
  localparam logic [ADDR_W-1:0] A_CCH  = ADDR_W'('h823);
  localparam logic [ADDR_W-1:0] A_MAP  = ADDR_W'('h850);

  localparam logic [7:0] V_CPU  = 8'hEF;
  localparam logic [7:0] V_FEAT = 8'hAD;
  localparam logic [7:0] V_STAT = 8'hE0;
  localparam logic [7:0] V_EQP  = 8'h3C;
  localparam logic [7:0] V_XFT  = 8'h39;
  localparam logic [7:0] V_KEY  = 8'h00;
  localparam logic [7:0] V_CCH  = 8'h03;
  localparam logic [7:0] V_NONE = 8'hFF;
  localparam logic [7:0] CTL_MASK = 8'h0F;

  logic [7:0] ctl_q;
  logic [7:0] rd_next;
  logic       wr_known;

  assign wr_known = (bus_addr == A_P92)  || (bus_addr == A_CPU) ||
                    (bus_addr == A_FEAT) || (bus_addr == A_STAT) ||
                    (bus_addr == A_DISK) || (bus_addr == A_LK1) ||
                    (bus_addr == A_LK2)  || (bus_addr == A_L2) ||
                    (bus_addr == A_CTL)  || (bus_addr == A_MAP);

  always_comb begin
    case (bus_addr)
      A_P92:   rd_next = {6'b0, little_endian, 1'b0};
      A_CPU:   rd_next = V_CPU;
      A_FEAT:  rd_next = V_FEAT;
      A_STAT:  rd_next = V_STAT;
      A_EQP:   rd_next = V_EQP;
      A_LK1:   rd_next = V_XFT;
      A_KEY:   rd_next = V_KEY;
      A_CTL:   rd_next = ctl_q;
      A_CCH:   rd_next = V_CCH;
      A_MAP:   rd_next = {7'b0, contig_map};
      default: rd_next = V_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_reset    <= 1'b0;
      little_endian <= 1'b0;
      disk_led      <= 1'b0;
      contig_map    <= 1'b0;
      ctl_q         <= 8'h00;
      wr_miss       <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == A_P92) begin
        soft_reset    <= bus_wdata[0];
        little_endian <= bus_wdata[1];
      end
      if (bus_addr == A_DISK) disk_led <= bus_wdata[0];
      if (bus_addr == A_CTL)  ctl_q <= bus_wdata & CTL_MASK;
      if (bus_addr == A_MAP)  contig_map <= bus_wdata[0];
      if (!wr_known)          wr_miss <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock1_pulse <= 1'b0;
      lock2_pulse <= 1'b0;
    end else begin
      lock1_pulse <= bus_wr && (bus_addr == A_LK1);
      lock2_pulse <= bus_wr && (bus_addr == A_LK2);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= 8'h00;
    else if (bus_rd) bus_rdata <= rd_next;
  end

endmodule

// File: rtl/sysport_regs_chk.sv
module sysport_regs_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_rdata,
  input logic              soft_reset,
  input logic              little_endian,
  input logic              disk_led,
  input logic              contig_map,
  input logic              lock1_pulse,
  input logic              lock2_pulse,
  input logic              wr_miss
);

  logic wr92, wr808, wr810, wr812, wr850, rd92, rd81c, rd814;
  assign wr92  = bus_wr && bus_addr == ADDR_W'('h092);
  assign wr808 = bus_wr && bus_addr == ADDR_W'('h808);
  assign wr810 = bus_wr && bus_addr == ADDR_W'('h810);
  assign wr812 = bus_wr && bus_addr == ADDR_W'('h812);
  assign wr850 = bus_wr && bus_addr == ADDR_W'('h850);
  assign rd92  = bus_rd && bus_addr == ADDR_W'('h092);
  assign rd81c = bus_rd && bus_addr == ADDR_W'('h81C);
  assign rd814 = bus_rd && bus_addr == ADDR_W'('h814);

  AST_P92_WRITE: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(wr92)) |-> (soft_reset == $past(bus_wdata[0]) && little_endian == $past(bus_wdata[1]))); // R1
  AST_P92_READ: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(rd92)) |-> (bus_rdata[7:2] == 6'b0 && bus_rdata[0] == 1'b0)); // R2
  AST_DISK_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(wr808)) |-> $stable(disk_led)); // R5
  AST_LOCK1_SRC: assert property (@(posedge clk) disable iff (rst)
    lock1_pulse |-> ($past(wr810) && $past(!rst))); // R6
  AST_LOCK2_SRC: assert property (@(posedge clk) disable iff (rst)
    lock2_pulse |-> ($past(wr812) && $past(!rst))); // R6
  AST_LOCK_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lock1_pulse, lock2_pulse})); // R6
  AST_CTL_UPPER: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(rd81c)) |-> (bus_rdata[7:4] == 4'b0)); // R7
  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(wr850)) |-> $stable(contig_map)); // R8
  AST_L2_READ: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(rd814)) |-> (bus_rdata == 8'hFF)); // R9
  AST_MISS_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(wr_miss)) |-> wr_miss); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (!soft_reset && !little_endian && !disk_led && !contig_map && !wr_miss && bus_rdata == 8'h00)); // R11
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(bus_rd)) |-> $stable(bus_rdata)); // R12

endmodule

bind sysport_regs sysport_regs_chk #(.ADDR_W(ADDR_W)) chk (.*);

// File: tb/sysport_regs_test.sv
module sysport_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic soft_reset, little_endian, disk_led, contig_map, lock1_pulse, lock2_pulse, wr_miss;

  int n_run = 0, n_fail = 0;
  logic m_le = 1'b0, m_map = 1'b0;
  logic [3:0] m_ctl = 4'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysport_regs #(.ADDR_W(AW)) uut (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] exp_rd(int a);
    case (a)
      'h092: return {6'b0, m_le, 1'b0};
      'h800: return 8'hEF;
      'h802: return 8'hAD;
      'h803: return 8'hE0;
      'h80C: return 8'h3C;
      'h810: return 8'h39;
      'h818: return 8'h00;
      'h81C: return {4'b0, m_ctl};
      'h823: return 8'h03;
      'h850: return {7'b0, m_map};
      default: return 8'hFF;
    endcase
  endfunction

  function automatic bit known_wr(int a);
    return a == 'h092 || a == 'h800 || a == 'h802 || a == 'h803 || a == 'h808 ||
           a == 'h810 || a == 'h812 || a == 'h814 || a == 'h81C || a == 'h850;
  endfunction

  task automatic sweep_reads(string tag);
    logic [7:0] d;
    int bad = 0;
    for (int a = 0; a < (1 << AW); a++) begin
      rd(a, d);
      if (d !== exp_rd(a)) begin
        bad++;
        if (bad < 5) $display("FAIL %s: addr %h actual %h expected %h", tag, a, d, exp_rd(a));
      end
    end
    n_run++;
    if (bad != 0) n_fail++;
  endtask

  function automatic logic [7:0] outs();
    return {1'b0, soft_reset, little_endian, disk_led, contig_map, lock1_pulse, lock2_pulse, wr_miss};
  endfunction

  initial begin
    logic [7:0] d;
    logic [7:0] snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R11 reset outputs", outs(), 8'h00);
    check("R11 reset rdata", bus_rdata, 8'h00);

    sweep_reads("R3 R9 R2 sweep state A");

    wr('h092, 8'h03);
    check("R1 p92 both set", {soft_reset, little_endian}, 8'h03);
    m_le = 1'b1;
    wr('h092, 8'hFE);
    check("R1 p92 reset low, le high", {soft_reset, little_endian}, 8'h01);
    rd('h092, d); check("R2 p92 read", d, 8'h02);

    wr('h808, 8'h01); check("R5 led on", disk_led, 1'b1);
    rd('h808, d);     check("R5 led port reads ones", d, 8'hFF);
    wr('h808, 8'hFE); check("R5 led off", disk_led, 1'b0);
    wr('h808, 8'h01);

    wr('h81C, 8'hA5); m_ctl = 4'h5;
    rd('h81C, d); check("R7 ctl low nibble", d, 8'h05);
    wr('h81C, 8'hFB); m_ctl = 4'hB;
    rd('h81C, d); check("R7 ctl mask", d, 8'h0B);

    wr('h850, 8'hFF); m_map = 1'b1;
    check("R8 map output", contig_map, 1'b1);
    rd('h850, d); check("R8 map read", d, 8'h01);

    @(negedge clk); bus_addr = AW'('h810); bus_wdata = 8'h00; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    check("R6 lock1 pulse high", {lock1_pulse, lock2_pulse}, 8'h02);
    @(negedge clk);
    check("R6 lock1 pulse one cycle", {lock1_pulse, lock2_pulse}, 8'h00);
    @(negedge clk); bus_addr = AW'('h812); bus_wdata = 8'h5A; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    check("R6 lock2 pulse high", {lock1_pulse, lock2_pulse}, 8'h01);
    @(negedge clk);
    check("R6 lock2 pulse one cycle", {lock1_pulse, lock2_pulse}, 8'h00);

    snap = outs();
    wr('h800, 8'h00); wr('h802, 8'h11); wr('h803, 8'h22); wr('h814, 8'hFF);
    check("R4 ro writes leave outputs", outs(), snap);
    rd('h800, d); check("R4 ro 0x800", d, 8'hEF);
    rd('h802, d); check("R4 ro 0x802", d, 8'hAD);
    rd('h803, d); check("R4 ro 0x803", d, 8'hE0);
    check("R10 no miss on known", wr_miss, 1'b0);

    sweep_reads("R3 R9 R7 R8 sweep state B");

    rd('h823, d);
    repeat (4) @(negedge clk);
    check("R12 rdata holds", bus_rdata, 8'h03);

    for (int a = 0; a < (1 << AW); a++)
      if (!known_wr(a)) wr(a, 8'hFF);
    check("R10 miss set", wr_miss, 1'b1);
    check("R10 outputs unchanged", outs() & 8'hFE, snap & 8'hFE);
    rd('h81C, d); check("R10 ctl unchanged", d, 8'h0B);
    rd('h850, d); check("R10 map unchanged", d, 8'h01);
    wr('h092, 8'h02);
    check("R10 miss sticky", wr_miss, 1'b1);

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_le = 1'b0; m_map = 1'b0; m_ctl = 4'h0;
    check("R11 reset clears outputs", outs(), 8'h00);
    check("R11 reset clears rdata", bus_rdata, 8'h00);
    rd('h81C, d); check("R11 ctl cleared", d, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule